// File: doc/BRIEF.md
# Cache Coherence Invariant Monitor

This block watches the coherence state that a group of caches hold for one memory block and reports any global combination of states that breaks the safety rules of the chosen protocol. Every cycle it counts how many caches sit in each state. It then applies exclusivity rules built from those counts. The rule set depends on the protocol mode. In the three-state mode, a cache can be invalid, valid or dirty. In the four-state mode, a cache can be invalid, shared, valid-exclusive or dirty.

The monitor sits beside the coherence logic and only observes it. It does not model the transitions between states, and it does not look at data. Violations set sticky flags that hold until a synchronous clear. The monitor also records the value of a free-running cycle counter at the first violation, so a debug session can find the cycle where the trouble began.

Top module: `coh_monitor`

## Requirements
- R1: Cache i drives bits [2i+1:2i] of `line_st`, with codes 00 invalid, 01 shared/valid, 10 valid-exclusive and 11 dirty. `cnt_inv`, `cnt_shr`, `cnt_exc` and `cnt_dty` give the number of caches holding each code, as combinational functions of the current vector, and they always sum to NUM_CACHES.
- R2: Flag bit 0 marks more than one dirty cache, in both modes.
- R3: Flag bit 1 marks a dirty cache together with at least one cache in code 01, in both modes.
- R4: In mode 1 (`proto_sel`=1), flag bit 2 marks a dirty cache together with at least one valid-exclusive cache.
- R5: In mode 1, flag bit 3 marks more than one valid-exclusive cache.
- R6: In mode 1, flag bit 4 marks a shared cache together with a valid-exclusive cache.
- R7: In mode 0, any cache with code 10 sets flag bit 5 (illegal encoding). In mode 0, bits 2 to 4 never set.
- R8: A flag appears at the clock edge that samples the offending vector, so it is visible in the next cycle. It then stays set, whatever the inputs, until it is cleared.
- R9: When `clr` is high at a clock edge, all flags and `stamp_valid` go to zero. This clear takes priority over a violation sampled at the same edge.
- R10: An internal cycle counter reads 0 during the first cycle after reset is released and advances by one each cycle. At the first violation after reset or clear, `first_stamp` takes the counter value of the cycle in which the vector was presented, and `stamp_valid` rises. Later violations leave both unchanged.
- R11: With NUM_CACHES=1, flag bits 0 to 4 never set in either mode. Bit 5 still reports code 10 in mode 0.
- R12: After reset, all flags, `first_stamp` and `stamp_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags and stamp |
| proto_sel | input | 1 | 0: three-state rules, 1: four-state rules |
| line_st | input | 2*NUM_CACHES | Packed per-cache state codes |
| viol_flags | output | 6 | Sticky violation flags, bit meanings per R2 to R7 |
| first_stamp | output | STAMP_W | Cycle counter value at the first violation |
| stamp_valid | output | 1 | `first_stamp` holds a captured value |
| cnt_inv | output | CNT_W | Caches in code 00 |
| cnt_shr | output | CNT_W | Caches in code 01 |
| cnt_exc | output | CNT_W | Caches in code 10 |
| cnt_dty | output | CNT_W | Caches in code 11 |

## Verification
The assertions assume that `proto_sel` and `line_st` are settled before each sampling edge. They also assume that `clr` is low throughout reset, so that the clear check does not see a stale request. The stimulus changes all inputs only on the falling clock edge and keeps `clr` low during reset. Outside the bench, the stimulus mixes legal and illegal state combinations in both modes, including code 10 in mode 0. This exercises the encoding-error path the monitor is meant to catch and does not restrict the inputs to legal protocol states.

// File: rtl/coh_mon_pkg.sv
// Package: shared state codes and flag positions for the coherence monitor.
// Assumes every consumer decodes line states with these two-bit codes.
package coh_mon_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_EXC = 2'b10,
        ST_DTY = 2'b11
    } line_state_e;

    localparam int NUM_FLAGS     = 6;
    localparam int F_MULTI_DTY   = 0;
    localparam int F_DTY_SHR     = 1;
    localparam int F_DTY_EXC     = 2;
    localparam int F_MULTI_EXC   = 3;
    localparam int F_SHR_EXC     = 4;
    localparam int F_BAD_CODE    = 5;
endpackage

// File: rtl/coh_pop_count.sv
// Module: coh_pop_count
// Counts how many caches hold each of the four state codes.
// Assumes line_st packs cache i in bits [2i+1:2i]; output is combinational.
module coh_pop_count
    import coh_mon_pkg::*;
#(
    parameter int NUM_CACHES = 8,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2*NUM_CACHES-1:0]   line_st,
    output logic [CNT_W-1:0]          cnt_inv,
    output logic [CNT_W-1:0]          cnt_shr,
    output logic [CNT_W-1:0]          cnt_exc,
    output logic [CNT_W-1:0]          cnt_dty
);
    logic [NUM_CACHES-1:0] is_inv, is_shr, is_exc, is_dty;

    // Per-cache one-hot decode of the state code.
    for (genvar g = 0; g < NUM_CACHES; g++) begin : g_dec
        always_comb begin
            is_inv[g] = (line_st[2*g +: 2] == ST_INV);
            is_shr[g] = (line_st[2*g +: 2] == ST_SHR);
            is_exc[g] = (line_st[2*g +: 2] == ST_EXC);
            is_dty[g] = (line_st[2*g +: 2] == ST_DTY);
        end
    end

    // Population count of each decoded state.
    always_comb begin
        cnt_inv = '0;
        cnt_shr = '0;
        cnt_exc = '0;
        cnt_dty = '0;
        for (int i = 0; i < NUM_CACHES; i++) begin
            cnt_inv = cnt_inv + CNT_W'(is_inv[i]);
            cnt_shr = cnt_shr + CNT_W'(is_shr[i]);
            cnt_exc = cnt_exc + CNT_W'(is_exc[i]);
            cnt_dty = cnt_dty + CNT_W'(is_dty[i]);
        end
    end

    AST_COUNT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_inv) + int'(cnt_shr) + int'(cnt_exc) + int'(cnt_dty)) == NUM_CACHES); // R1
endmodule

// File: rtl/coh_rule_eval.sv
// Module: coh_rule_eval
// Applies the exclusivity rules of the selected protocol to the state counts.
// Assumes counts come from coh_pop_count in the same cycle; output is combinational.
module coh_rule_eval
    import coh_mon_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 proto_sel,
    input  logic [CNT_W-1:0]     cnt_shr,
    input  logic [CNT_W-1:0]     cnt_exc,
    input  logic [CNT_W-1:0]     cnt_dty,
    output logic [NUM_FLAGS-1:0] viol_now
);
    logic any_shr, any_exc, any_dty, many_dty, many_exc;

    // Presence and multiplicity predicates from the counts.
    always_comb begin
        any_shr  = (cnt_shr != '0);
        any_exc  = (cnt_exc != '0);
        any_dty  = (cnt_dty != '0);
        many_dty = (cnt_dty > CNT_W'(1));
        many_exc = (cnt_exc > CNT_W'(1));
    end

    // Rule selection by protocol mode.
    always_comb begin
        viol_now              = '0;
        viol_now[F_MULTI_DTY] = many_dty;
        viol_now[F_DTY_SHR]   = any_dty && any_shr;
        if (proto_sel) begin
            viol_now[F_DTY_EXC]   = any_dty && any_exc;
            viol_now[F_MULTI_EXC] = many_exc;
            viol_now[F_SHR_EXC]   = any_shr && any_exc;
        end else begin
            viol_now[F_BAD_CODE]  = any_exc;
        end
    end

    AST_MODE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !proto_sel |-> (viol_now[F_SHR_EXC:F_DTY_EXC] == '0)); // R7
    AST_MODE1_NO_BADCODE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_sel |-> !viol_now[F_BAD_CODE]); // R7
endmodule

// File: rtl/coh_viol_latch.sv
// Module: coh_viol_latch
// Holds sticky violation flags and stamps the cycle of the first violation.
// Assumes clr is a single synchronous request; clear beats a same-cycle violation.
module coh_viol_latch
    import coh_mon_pkg::*;
#(
    parameter int STAMP_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_FLAGS-1:0] viol_now,
    output logic [NUM_FLAGS-1:0] flags_q,
    output logic [STAMP_W-1:0]   stamp_q,
    output logic                 stamp_vld
);
    logic [STAMP_W-1:0] cyc_q;

    // Free-running cycle counter, zero in the first cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_q + STAMP_W'(1);
    end

    // Sticky flag accumulation with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flags_q <= '0;
        else               flags_q <= flags_q | viol_now;
    end

    // One-shot capture of the first violation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stamp_q   <= '0;
            stamp_vld <= 1'b0;
        end else if (!stamp_vld && (viol_now != '0)) begin
            stamp_q   <= cyc_q;
            stamp_vld <= 1'b1;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags_q == '0 && !stamp_vld)); // R9
    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_vld && !clr) |=> $stable(stamp_q)); // R10
endmodule

// File: rtl/coh_monitor.sv
// Module: coh_monitor (top)
// Observes per-cache coherence states of one block and flags protocol violations.
// Assumes inputs are stable around the clock edge; it never drives the caches.
module coh_monitor
    import coh_mon_pkg::*;
#(
    parameter int NUM_CACHES = 8,
    parameter int STAMP_W    = 16,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      proto_sel,
    input  logic [2*NUM_CACHES-1:0]   line_st,
    output logic [NUM_FLAGS-1:0]      viol_flags,
    output logic [STAMP_W-1:0]        first_stamp,
    output logic                      stamp_valid,
    output logic [CNT_W-1:0]          cnt_inv,
    output logic [CNT_W-1:0]          cnt_shr,
    output logic [CNT_W-1:0]          cnt_exc,
    output logic [CNT_W-1:0]          cnt_dty
);
    logic [NUM_FLAGS-1:0] viol_now;

    coh_pop_count #(.NUM_CACHES(NUM_CACHES), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .line_st(line_st),
        .cnt_inv(cnt_inv), .cnt_shr(cnt_shr), .cnt_exc(cnt_exc), .cnt_dty(cnt_dty)
    );

    coh_rule_eval #(.CNT_W(CNT_W)) u_rules (
        .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel),
        .cnt_shr(cnt_shr), .cnt_exc(cnt_exc), .cnt_dty(cnt_dty),
        .viol_now(viol_now)
    );

    coh_viol_latch #(.STAMP_W(STAMP_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .clr(clr), .viol_now(viol_now),
        .flags_q(viol_flags), .stamp_q(first_stamp), .stamp_vld(stamp_valid)
    );

    AST_FLAG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((viol_now != '0) && !clr) |=> ((viol_flags & $past(viol_now)) == $past(viol_now))); // R8

    if (NUM_CACHES == 1) begin : g_single
        AST_SINGLE_NO_COEX: assert property (@(posedge clk) disable iff (!rst_n)
            viol_now[F_SHR_EXC:F_MULTI_DTY] == '0); // R11
    end
endmodule

// File: tb/tb_coh_monitor.sv
module tb_coh_monitor;
    localparam int N = 8;
    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic proto_sel = 1'b0;
    logic [2*N-1:0] line_st = '0;
    logic [5:0] viol_flags;
    logic [SW-1:0] first_stamp;
    logic stamp_valid;
    logic [3:0] cnt_inv, cnt_shr, cnt_exc, cnt_dty;

    logic [1:0] line1 = 2'b00;
    logic [5:0] flags1;
    logic [SW-1:0] stamp1;
    logic valid1;
    logic c1i, c1s, c1e, c1d;

    int nchk = 0;
    int nerr = 0;
    int tbcyc = 0;
    int wd = 0;
    bit done = 0;

    always #4 clk = ~clk;

    coh_monitor #(.NUM_CACHES(N), .STAMP_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .proto_sel(proto_sel), .line_st(line_st),
        .viol_flags(viol_flags), .first_stamp(first_stamp), .stamp_valid(stamp_valid),
        .cnt_inv(cnt_inv), .cnt_shr(cnt_shr), .cnt_exc(cnt_exc), .cnt_dty(cnt_dty)
    );

    coh_monitor #(.NUM_CACHES(1), .STAMP_W(SW)) dut1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .proto_sel(proto_sel), .line_st(line1),
        .viol_flags(flags1), .first_stamp(stamp1), .stamp_valid(valid1),
        .cnt_inv(c1i), .cnt_shr(c1s), .cnt_exc(c1e), .cnt_dty(c1d)
    );

    // Bench-side cycle index since reset release.
    always @(posedge clk) begin
        if (!rst_n) tbcyc <= 0;
        else        tbcyc <= tbcyc + 1;
    end

    // Table entry: {mode, vector[15:0], expected flags[5:0]}.
    localparam logic [22:0] TBL [14] = '{
        {1'b0, 16'h0000, 6'b000000},
        {1'b0, 16'h0003, 6'b000000},
        {1'b0, 16'h0007, 6'b000010},
        {1'b0, 16'h000F, 6'b000001},
        {1'b0, 16'h5555, 6'b000000},
        {1'b0, 16'h8000, 6'b100000},
        {1'b1, 16'h0002, 6'b000000},
        {1'b1, 16'h000A, 6'b001000},
        {1'b1, 16'h0006, 6'b010000},
        {1'b1, 16'h000E, 6'b000100},
        {1'b1, 16'h0007, 6'b000010},
        {1'b1, 16'h5555, 6'b000000},
        {1'b1, 16'h009F, 6'b010111},
        {1'b0, 16'h000E, 6'b100000}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int count_code(logic [2*N-1:0] v, logic [1:0] code);
        int n = 0;
        for (int i = 0; i < N; i++) if (v[2*i +: 2] == code) n++;
        return n;
    endfunction

    function automatic string tag_for(logic [5:0] f);
        if (f[5]) return "R7";
        if (f[4]) return "R6";
        if (f[3]) return "R5";
        if (f[2]) return "R4";
        if (f[1]) return "R3";
        if (f[0]) return "R2";
        return "R8";
    endfunction

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; line_st = '0; line1 = 2'b00;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000 && !done) begin
            done = 1;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int stamp_exp;
        repeat (3) @(negedge clk);
        chk("R12 flags", 32'(viol_flags), 0);
        chk("R12 stamp", 32'(first_stamp), 0);
        chk("R12 valid", 32'(stamp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 flags after release", 32'(viol_flags), 0);

        // Table walk.
        for (int k = 0; k < 14; k++) begin
            logic [5:0] ef;
            string t;
            do_clear();
            proto_sel = TBL[k][22];
            line_st = TBL[k][21:6];
            ef = TBL[k][5:0];
            t = tag_for(ef);
            stamp_exp = tbcyc;
            #1;
            chk("R1 inv", 32'(cnt_inv), 32'(count_code(line_st, 2'b00)));
            chk("R1 shr", 32'(cnt_shr), 32'(count_code(line_st, 2'b01)));
            chk("R1 exc", 32'(cnt_exc), 32'(count_code(line_st, 2'b10)));
            chk("R1 dty", 32'(cnt_dty), 32'(count_code(line_st, 2'b11)));
            @(negedge clk);
            chk(t, 32'(viol_flags), 32'(ef));
            chk("R10 valid", 32'(stamp_valid), 32'(ef != 0));
            if (ef != 0) chk("R10 stamp", 32'(first_stamp), 32'(stamp_exp[SW-1:0]));
            line_st = '0;
            @(negedge clk);
            chk("R8 sticky", 32'(viol_flags), 32'(ef));
        end

        // Clear wins over a same-cycle violation.
        @(negedge clk);
        clr = 1'b1; proto_sel = 1'b0; line_st = 16'h000F;
        @(negedge clk);
        chk("R9 clear priority flags", 32'(viol_flags), 0);
        chk("R9 clear priority valid", 32'(stamp_valid), 0);
        clr = 1'b0;
        stamp_exp = tbcyc;
        @(negedge clk);
        chk("R9 after clear", 32'(viol_flags), 32'b000001);
        chk("R10 stamp first", 32'(first_stamp), 32'(stamp_exp[SW-1:0]));

        // Later violation accumulates but leaves the stamp.
        line_st = '0;
        repeat (3) @(negedge clk);
        line_st = 16'h0007;
        @(negedge clk);
        line_st = '0;
        chk("R8 accumulate", 32'(viol_flags), 32'b000011);
        chk("R10 stamp held", 32'(first_stamp), 32'(stamp_exp[SW-1:0]));

        // Clear in idle returns everything to zero.
        do_clear();
        chk("R9 idle clear", 32'(viol_flags), 0);
        chk("R9 idle clear stamp", 32'(stamp_valid), 0);

        // Single-cache instance: no coexistence rule can fire.
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 4; c++) begin
                do_clear();
                proto_sel = m[0];
                line1 = c[1:0];
                @(negedge clk);
                chk("R11 single no coexist", 32'(flags1[4:0]), 0);
                chk("R11 single bad code", 32'(flags1[5]), 32'(m == 0 && c == 2));
                line1 = 2'b00;
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule